// File: doc/BRIEF.md
# Single-Slope Ramp Converter Controller

This block sequences a single-slope analog-to-digital conversion. An external integrator produces a rising ramp, and an external comparator goes high once the ramp has climbed past the voltage being measured. The controller opens a counting gate when the ramp starts and counts clock cycles while that gate is open. It closes the gate when the comparator trips. The cycle count is the conversion result.

After each conversion the controller captures the count and flags completion for one cycle. It then holds the integrator in discharge for a fixed number of clocks. While the run input stays high, it starts the next ramp without further prompting. If the ramp never trips the comparator, the counter stops at full scale and an over-range flag is raised.

The comparator output is asynchronous to the controller clock. It passes through a two-stage synchroniser before the control logic uses it, so that synchroniser latency forms part of every measured count.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block enters idle: `gate_o`=0, `disch_o`=1, `done_o`=0, `result_o`=0, `ovr_o`=0.
- R2: `gate_o` and `disch_o` are never high in the same cycle, and `gate_o` only rises after a cycle with `disch_o` high.
- R3: Each conversion holds `gate_o` high for exactly `result_o`+1 consecutive cycles. The internal count starts at 0 and rises by one on every gated edge except the closing one.
- R4: `cmp_i` passes through two flip-flops. If `cmp_i` goes high after the Nth gated cycle has begun (and before its closing edge), `result_o` becomes N+1. The gate closes three rising edges after `cmp_i` goes high.
- R5: `done_o` is high for exactly one cycle, on the edge where `gate_o` falls. `result_o` and `ovr_o` change only on that edge.
- R6: If the count reaches 2^CNT_W-1 before the synchronised comparator is high, the conversion ends on the next edge with `result_o` all ones and `ovr_o`=1. A comparator seen on that same edge takes priority, giving `ovr_o`=0.
- R7: After every conversion, and when leaving idle, `disch_o` stays high for exactly DISCH_CYC cycles before `gate_o` rises.
- R8: If `run_i` is low when the discharge interval ends, the block stays idle. In idle `gate_o`=0 and `disch_o`=1, and `result_o` and `ovr_o` keep their last values. A conversion already under way when `run_i` falls still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; also the counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Level: keep converting while high |
| cmp_i | input | 1 | Asynchronous comparator, high once the ramp has passed the input |
| disch_o | output | 1 | Discharge the integrator (hold the ramp at zero) |
| gate_o | output | 1 | Counting gate, high while the ramp rises |
| result_o | output | CNT_W | Count captured at the end of the last conversion |
| done_o | output | 1 | One-cycle pulse when a new result is captured |
| ovr_o | output | 1 | Last conversion ended at full scale without a comparator trip |

## Verification
The bound checker watches several properties on every cycle:
- `gate_o` and `disch_o` never overlap, and a ramp only starts out of discharge.
- `done_o` is a single-cycle pulse that coincides with the gate closing.
- The result and over-range flag hold steady between completions.
- An over-range result is always all ones.

Other properties need a bench model of the comparator:
- The exact relation between the comparator trip time and the captured count, including the three-edge latency.
- Where over-range wins or loses against a late comparator trip.
- The exact discharge length.
- The stop that follows when `run_i` falls.

The bench therefore trips a modelled comparator after chosen numbers of gated cycles.

// File: rtl/ramp_adc_pkg.sv
// Package: shared types for the ramp converter controller.
// Assumes nothing beyond a single clock domain for the control logic.
package ramp_adc_pkg;

    // Controller phases: idle (held discharged), discharge dwell, ramp/count.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DISCH = 2'd1,
        ST_RAMP  = 2'd2
    } ramp_state_e;

endpackage

// File: rtl/ramp_adc_sync.sv
// Module: multi-stage synchroniser for one asynchronous level.
// Assumes STAGES >= 2; the output lags the input by STAGES rising edges.
module ramp_adc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/ramp_adc_counter.sv
// Module: gated up-counter that measures ramp time in clock cycles.
// Assumes the controller stops incrementing at full scale (no wrap needed).
module ramp_adc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         full_o
);
    // Clear while the gate is shut, count one per gated clock.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_o <= '0;
        else if (inc_i)      cnt_o <= cnt_o + 1'b1;
    end

    assign full_o = &cnt_o;
endmodule

// File: rtl/ramp_adc_dwell.sv
// Module: down-counter that times the integrator discharge interval.
// Assumes CYCLES >= 2; after load the expired flag rises CYCLES-1 edges later.
module ramp_adc_dwell #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] left;

    // Reload on entry to discharge, then count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         left <= '0;
        else if (load_i)    left <= TW'(CYCLES - 1);
        else if (left != 0) left <= left - 1'b1;
    end

    assign expired_o = (left == '0);
endmodule

// File: rtl/ramp_adc_ctrl.sv
// Module: single-slope ramp converter controller (top).
// Sequences discharge -> ramp/count -> capture, and repeats while run_i is high.
// Assumes the comparator falls low during discharge within DISCH_CYC - SYNC_STAGES
// cycles, and DISCH_CYC >= SYNC_STAGES so a stale trip is never seen in a ramp.
module ramp_adc_ctrl
    import ramp_adc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int DISCH_CYC   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             cmp_i,
    output logic             disch_o,
    output logic             gate_o,
    output logic [CNT_W-1:0] result_o,
    output logic             done_o,
    output logic             ovr_o
);
    ramp_state_e       st, st_nxt;
    logic              cmp_s;
    logic              dwell_load, dwell_done;
    logic              cnt_full;
    logic [CNT_W-1:0]  cnt;
    logic              stop, over;

    ramp_adc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_i),
        .q_o   (cmp_s)
    );

    ramp_adc_dwell #(.CYCLES(DISCH_CYC)) u_dwell (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (dwell_load),
        .expired_o (dwell_done)
    );

    ramp_adc_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (st != ST_RAMP),
        .inc_i  ((st == ST_RAMP) && !stop),
        .cnt_o  (cnt),
        .full_o (cnt_full)
    );

    // Next-phase decision; the comparator outranks the full-scale stop.
    always_comb begin
        st_nxt     = st;
        dwell_load = 1'b0;
        stop       = 1'b0;
        over       = 1'b0;
        case (st)
            ST_IDLE: begin
                if (run_i) begin
                    st_nxt     = ST_DISCH;
                    dwell_load = 1'b1;
                end
            end
            ST_DISCH: begin
                if (dwell_done) st_nxt = run_i ? ST_RAMP : ST_IDLE;
            end
            ST_RAMP: begin
                if (cmp_s) begin
                    stop = 1'b1;
                end else if (cnt_full) begin
                    stop = 1'b1;
                    over = 1'b1;
                end
                if (stop) begin
                    st_nxt     = ST_DISCH;
                    dwell_load = 1'b1;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Capture the count and flags on the edge the gate closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            ovr_o    <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= stop;
            if (stop) begin
                result_o <= cnt;
                ovr_o    <= over;
            end
        end
    end

    assign gate_o  = (st == ST_RAMP);
    assign disch_o = (st != ST_RAMP);
endmodule

// File: rtl/ramp_adc_checker.sv
// Module: protocol checker for ramp_adc_ctrl, attached by bind.
// Assumes synchronous active-low reset; observes top-level ports only.
module ramp_adc_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disch_o,
    input logic             gate_o,
    input logic [CNT_W-1:0] result_o,
    input logic             done_o,
    input logic             ovr_o
);
    a_r2_gate_disch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o && disch_o));

    a_r2_ramp_from_disch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(disch_o));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r5_done_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!gate_o && $past(gate_o)));

    a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> ($stable(result_o) || $past(done_o, 1) == 1'b0 && done_o));

    a_r5_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done_o) && !done_o |-> $stable(ovr_o));

    a_r6_ovr_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> (&result_o));
endmodule

bind ramp_adc_ctrl ramp_adc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .disch_o  (disch_o),
    .gate_o   (gate_o),
    .result_o (result_o),
    .done_o   (done_o),
    .ovr_o    (ovr_o)
);

// File: tb/ramp_adc_ctrl_test.sv
`timescale 1ns/1ps
// Bench: models the comparator as tripping after K gated cycles and checks
// captured counts, over-range, done pulse, discharge length and run stop.
module ramp_adc_ctrl_test;
    localparam int CNT_W = 8;
    localparam int DISCH = 4;
    localparam int MAXV  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             run_i;
    logic             cmp_i;
    logic             disch_o, gate_o, done_o, ovr_o;
    logic [CNT_W-1:0] result_o;

    int n_chk = 0;
    int n_err = 0;
    int drun  = 0;
    bit last_done = 1'b0;

    always #2.5 clk = ~clk;

    ramp_adc_ctrl #(.CNT_W(CNT_W), .DISCH_CYC(DISCH), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .cmp_i(cmp_i),
        .disch_o(disch_o), .gate_o(gate_o), .result_o(result_o),
        .done_o(done_o), .ovr_o(ovr_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected count for a comparator trip after k gated cycles (k=0: never).
    function automatic int exp_res(input int k);
        if (k != 0 && k + 1 <= MAXV) return k + 1;
        return MAXV;
    endfunction

    function automatic int exp_ovr(input int k);
        return (k != 0 && k + 1 <= MAXV) ? 0 : 1;
    endfunction

    // One conversion; chk_d enables the discharge length check, drop clears run.
    task automatic conv(input int k, input bit chk_d, input bit drop);
        int gn = 0;
        forever begin
            @(negedge clk);
            if (last_done) check(!done_o, "R5 done width", int'(done_o), 0);
            last_done = done_o;
            if (gate_o) begin
                gn++;
                if (gn == 1) begin
                    if (chk_d) check(drun == DISCH, "R7 discharge length", drun, DISCH);
                    drun = 0;
                    if (drop) run_i = 1'b0;
                end
                if (k != 0 && gn == k) cmp_i = 1'b1;
            end else begin
                if (disch_o) drun++;
                cmp_i = 1'b0;
            end
            if (done_o) begin
                check(int'(result_o) == exp_res(k), "R3/R4 result", int'(result_o), exp_res(k));
                check(int'(ovr_o) == exp_ovr(k), "R6 overrange", int'(ovr_o), exp_ovr(k));
                check(gn == int'(result_o) + 1, "R3 gate cycles", gn, int'(result_o) + 1);
                break;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        int held;
        void'($urandom(32'd1234));
        rst_n = 1'b0; run_i = 1'b0; cmp_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(gate_o == 1'b0, "R1 gate", int'(gate_o), 0);
        check(disch_o == 1'b1, "R1 disch", int'(disch_o), 1);
        check(done_o == 1'b0, "R1 done", int'(done_o), 0);
        check(result_o == '0, "R1 result", int'(result_o), 0);
        check(ovr_o == 1'b0, "R1 ovr", int'(ovr_o), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(gate_o == 1'b0 && disch_o, "R8 idle without run", int'(gate_o), 0);
        // R7: discharge from idle
        run_i = 1'b1;
        drun = 0;
        conv(1, 1'b1, 1'b0);
        // Directed corners: R6 boundary cases.
        conv(254, 1'b1, 1'b0);
        conv(255, 1'b1, 1'b0);
        conv(0, 1'b1, 1'b0);
        conv(2, 1'b1, 1'b0);
        conv(200, 1'b1, 1'b0);
        // Random trip points.
        for (int i = 0; i < 24; i++) begin
            conv(1 + int'($urandom % 253), 1'b1, 1'b0);
        end
        // R8: run dropped mid-ramp, conversion completes, then idle holds.
        conv(37, 1'b1, 1'b1);
        held = int'(result_o);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            cmp_i = 1'b0;
            if (gate_o || !disch_o || int'(result_o) != held || done_o) begin
                check(1'b0, "R8 idle hold", int'(result_o), held);
                break;
            end
        end
        check(int'(result_o) == held, "R8 result held", int'(result_o), held);
        // Restart: R7 from idle again.
        run_i = 1'b1;
        drun = 0;
        last_done = 1'b0;
        conv(90, 1'b1, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule